// File: doc/BRIEF.md
# Fence Slot Allocator

The block hands out a small pool of fence slots to a much larger population of client objects, each named by an ID. A client asks for a slot with a GET. If it already holds one, it keeps it. Otherwise it receives the lowest-numbered empty slot at or above a configurable first usable index. If no slot is empty, it takes the least recently used slot whose pin count is zero, and the displaced owner is told that it lost its fence. When every candidate is pinned, the request fails. The failure code says either "try again later" or "no slot".

The block does not program fence contents. It emits a single command per cycle, either "install owner X in slot N" or "clear slot N", for a downstream writer to act on. Slots can also be released, pinned and unpinned by index. A RESTORE operation replays the whole table after a reset of the downstream hardware.

The block accepts one operation per clock. Every accepted GET, RELEASE, PIN or UNPIN answers on the clock after it is sampled.

Top module: `fence_slot_alloc`

## Requirements
- R1: After reset, `busy`, `rsp_valid`, `cmd_valid` and `lost_valid` are 0, all slots are empty and unpinned, and recency ranks a lower slot index as older.
- R2: Opcodes are GET=0, RELEASE=1, PIN=2, UNPIN=3, RESTORE=4. Status codes are OK=0, RETRY=1, NOSLOT=2, REFUSED=3, PINERR=4. A GET from an ID that already owns a slot answers OK with that slot. It emits an install command only when `op_dirty` is 1.
- R3: A GET from an ID that owns no slot takes the lowest empty slot with index >= FIRST_SLOT. It answers OK with that slot and emits an install (`cmd_clear`=0, `cmd_id`=requester). Slots below FIRST_SLOT are never granted.
- R4: When no eligible slot is empty, a GET takes the least recently used slot among those with a zero pin count. It emits the install and pulses `lost_valid` with the previous owner in `lost_id`.
- R5: When every eligible slot is pinned, a GET answers RETRY if `retry_hint` is 1 and NOSLOT otherwise. It emits no command and changes no state.
- R6: Every granted GET, including a repeat by the current owner, makes its slot the most recently used.
- R7: RELEASE of an owned slot with a zero pin count emits a clear command, empties the slot and frees its owner. RELEASE of an empty slot answers OK with no command.
- R8: RELEASE of a slot with a nonzero pin count answers REFUSED. The owner stays in place and no command is emitted.
- R9: PIN adds one to the slot's pin count and UNPIN subtracts one. UNPIN at zero, or PIN at the maximum count, answers PINERR and leaves the count unchanged.
- R10: RESTORE raises `busy` on the next clock. It then emits one command per cycle for slots 0 to SLOTS-1 in ascending order: an install with the owner for an occupied slot, a clear for an empty one. `busy` falls with the last command.
- R11: Operations presented while `busy` is 1, and opcodes 5 to 7, are ignored. They produce no response and change no state.
- R12: Each response and each command appears exactly one clock after the operation is sampled, with `rsp_slot` naming the affected slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation code |
| op_id | input | ID_W | Requesting client ID (GET) |
| op_slot | input | log2(SLOTS) | Target slot (RELEASE, PIN, UNPIN) |
| op_dirty | input | 1 | Requester's parameters changed; reinstall on hit |
| retry_hint | input | 1 | A release is pending elsewhere; failed GET asks for retry |
| busy | output | 1 | RESTORE walk in progress |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 3 | Response status code |
| rsp_slot | output | log2(SLOTS) | Slot affected by the operation |
| cmd_valid | output | 1 | Command to the fence writer |
| cmd_clear | output | 1 | 1 = clear slot, 0 = install owner |
| cmd_slot | output | log2(SLOTS) | Slot the command targets |
| cmd_id | output | ID_W | Owner to install |
| lost_valid | output | 1 | An owner was displaced |
| lost_id | output | ID_W | Displaced owner |

## Verification
The hardest state to reach from the ports is a full table in which only some slots are pinned and recency differs from allocation order. Only that state shows whether the steal skips pinned entries and picks the true oldest. The stimulus uses more client IDs than slots, mixes random repeat GETs (which refresh recency) with random pins and unpins, and adds a directed pass that pins every slot to provoke both failure codes. A bench-side timestamp model predicts the victim independently of the age matrix.

// File: rtl/fa_pkg.sv
// Shared encodings for the fence slot allocator.
package fa_pkg;
    typedef enum logic [2:0] {
        OP_GET     = 3'd0,
        OP_RELEASE = 3'd1,
        OP_PIN     = 3'd2,
        OP_UNPIN   = 3'd3,
        OP_RESTORE = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_OK      = 3'd0,
        ST_RETRY   = 3'd1,
        ST_NOSLOT  = 3'd2,
        ST_REFUSED = 3'd3,
        ST_PINERR  = 3'd4
    } status_e;
endpackage

// File: rtl/fa_free_finder.sv
// Finds the lowest empty slot at or above FIRST_SLOT.
// Assumes: empty_mask bit i is 1 when slot i holds no owner.
module fa_free_finder #(
    parameter int SLOTS      = 8,
    parameter int FIRST_SLOT = 2,
    localparam int SLOT_W    = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0]  empty_mask,
    output logic              found,
    output logic [SLOT_W-1:0] idx
);
    // Priority scan from the top down so the lowest index wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = SLOTS - 1; i >= FIRST_SLOT; i--) begin
            if (empty_mask[i]) begin
                found = 1'b1;
                idx   = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/fa_lru_matrix.sv
// Age matrix over all slots: older_q[i][j]=1 means slot i was used before slot j.
// Assumes: at most one touch per clock; the relation is a total order from reset.
module fa_lru_matrix #(
    parameter int SLOTS   = 8,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              touch_en,
    input  logic [SLOT_W-1:0] touch_idx,
    input  logic [SLOTS-1:0]  cand_mask,
    output logic              found,
    output logic [SLOT_W-1:0] oldest_idx
);
    logic [SLOTS-1:0] older_q [SLOTS];
    logic [SLOTS-1:0] is_oldest;

    // Reset ranks lower indices as older; a touch makes the slot youngest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++)
                for (int j = 0; j < SLOTS; j++)
                    older_q[i][j] <= (i < j);
        end else if (touch_en) begin
            for (int j = 0; j < SLOTS; j++) begin
                if (SLOT_W'(j) != touch_idx) begin
                    older_q[touch_idx][j] <= 1'b0;
                    older_q[j][touch_idx] <= 1'b1;
                end
            end
        end
    end

    // A candidate is oldest when it is older than every other candidate.
    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            is_oldest[i] = cand_mask[i];
            for (int j = 0; j < SLOTS; j++)
                if (j != i && cand_mask[j] && !older_q[i][j])
                    is_oldest[i] = 1'b0;
        end
    end

    // Encode the single oldest candidate.
    always_comb begin
        found      = |is_oldest;
        oldest_idx = '0;
        for (int i = 0; i < SLOTS; i++)
            if (is_oldest[i]) oldest_idx = SLOT_W'(i);
    end
endmodule

// File: rtl/fence_slot_alloc.sv
// Fence slot allocator: owner table, pin counters, restore walker.
// Picks a slot by ownership hit, then lowest empty slot, then LRU unpinned slot.
// Assumes: op_slot < SLOTS; one operation per clock; each ID holds at most one slot.
module fence_slot_alloc
    import fa_pkg::*;
#(
    parameter int SLOTS      = 8,
    parameter int FIRST_SLOT = 2,
    parameter int ID_W       = 8,
    parameter int PIN_W      = 3,
    localparam int SLOT_W    = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [ID_W-1:0]   op_id,
    input  logic [SLOT_W-1:0] op_slot,
    input  logic              op_dirty,
    input  logic              retry_hint,
    output logic              busy,
    output logic              rsp_valid,
    output logic [2:0]        rsp_status,
    output logic [SLOT_W-1:0] rsp_slot,
    output logic              cmd_valid,
    output logic              cmd_clear,
    output logic [SLOT_W-1:0] cmd_slot,
    output logic [ID_W-1:0]   cmd_id,
    output logic              lost_valid,
    output logic [ID_W-1:0]   lost_id
);
    localparam logic [PIN_W-1:0] PIN_MAX = '1;

    logic [SLOTS-1:0]  valid_q;
    logic [ID_W-1:0]   owner_q [SLOTS];
    logic [PIN_W-1:0]  pin_q   [SLOTS];
    logic [SLOT_W-1:0] walk_q;

    logic              accept, is_get;
    logic [SLOTS-1:0]  hit_vec, cand_mask;
    logic              hit, free_found, victim_found, grant;
    logic [SLOT_W-1:0] hit_idx, free_idx, victim_idx, grant_idx;

    assign accept = op_valid && !busy;
    assign is_get = accept && (op_code == OP_GET);

    // Ownership lookup and steal-candidate mask.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < SLOTS; i++) begin
            hit_vec[i]   = valid_q[i] && (owner_q[i] == op_id);
            cand_mask[i] = valid_q[i] && (pin_q[i] == '0) && (i >= FIRST_SLOT);
            if (hit_vec[i]) hit_idx = SLOT_W'(i);
        end
        hit = |hit_vec;
    end

    fa_free_finder #(.SLOTS(SLOTS), .FIRST_SLOT(FIRST_SLOT)) u_free (
        .empty_mask (~valid_q),
        .found      (free_found),
        .idx        (free_idx)
    );

    fa_lru_matrix #(.SLOTS(SLOTS)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (is_get && grant),
        .touch_idx  (grant_idx),
        .cand_mask  (cand_mask),
        .found      (victim_found),
        .oldest_idx (victim_idx)
    );

    // Select the granted slot by priority: hit, empty, LRU victim.
    always_comb begin
        grant     = hit || free_found || victim_found;
        grant_idx = hit ? hit_idx : (free_found ? free_idx : victim_idx);
    end

    // Operation execution, restore walk and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            walk_q     <= '0;
            rsp_valid  <= 1'b0;
            rsp_status <= ST_OK;
            rsp_slot   <= '0;
            cmd_valid  <= 1'b0;
            cmd_clear  <= 1'b0;
            cmd_slot   <= '0;
            cmd_id     <= '0;
            lost_valid <= 1'b0;
            lost_id    <= '0;
            valid_q    <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                owner_q[i] <= '0;
                pin_q[i]   <= '0;
            end
        end else begin
            rsp_valid  <= 1'b0;
            cmd_valid  <= 1'b0;
            lost_valid <= 1'b0;
            if (busy) begin
                cmd_valid <= 1'b1;
                cmd_slot  <= walk_q;
                cmd_clear <= !valid_q[walk_q];
                cmd_id    <= owner_q[walk_q];
                if (walk_q == SLOT_W'(SLOTS - 1)) busy <= 1'b0;
                walk_q <= walk_q + 1'b1;
            end else if (op_valid) begin
                rsp_slot <= op_slot;
                case (op_code)
                    OP_GET: begin
                        rsp_valid <= 1'b1;
                        if (grant) begin
                            rsp_status <= ST_OK;
                            rsp_slot   <= grant_idx;
                            if (!hit || op_dirty) begin
                                cmd_valid <= 1'b1;
                                cmd_clear <= 1'b0;
                                cmd_slot  <= grant_idx;
                                cmd_id    <= op_id;
                            end
                            if (!hit && !free_found) begin
                                lost_valid <= 1'b1;
                                lost_id    <= owner_q[victim_idx];
                            end
                            valid_q[grant_idx] <= 1'b1;
                            owner_q[grant_idx] <= op_id;
                        end else begin
                            rsp_status <= retry_hint ? ST_RETRY : ST_NOSLOT;
                        end
                    end
                    OP_RELEASE: begin
                        rsp_valid <= 1'b1;
                        if (pin_q[op_slot] != '0) begin
                            rsp_status <= ST_REFUSED;
                        end else begin
                            rsp_status <= ST_OK;
                            if (valid_q[op_slot]) begin
                                cmd_valid        <= 1'b1;
                                cmd_clear        <= 1'b1;
                                cmd_slot         <= op_slot;
                                valid_q[op_slot] <= 1'b0;
                            end
                        end
                    end
                    OP_PIN: begin
                        rsp_valid <= 1'b1;
                        if (pin_q[op_slot] == PIN_MAX) begin
                            rsp_status <= ST_PINERR;
                        end else begin
                            rsp_status     <= ST_OK;
                            pin_q[op_slot] <= pin_q[op_slot] + 1'b1;
                        end
                    end
                    OP_UNPIN: begin
                        rsp_valid <= 1'b1;
                        if (pin_q[op_slot] == '0) begin
                            rsp_status <= ST_PINERR;
                        end else begin
                            rsp_status     <= ST_OK;
                            pin_q[op_slot] <= pin_q[op_slot] - 1'b1;
                        end
                    end
                    OP_RESTORE: begin
                        busy   <= 1'b1;
                        walk_q <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/fence_slot_alloc_chk.sv
// Port-level protocol checks for fence_slot_alloc, attached by bind.
// Assumes: status codes from fa_pkg; FIRST_SLOT matches the bound instance.
module fence_slot_alloc_chk
    import fa_pkg::*;
#(
    parameter int SLOTS      = 8,
    parameter int FIRST_SLOT = 2,
    localparam int SLOT_W    = $clog2(SLOTS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              rsp_valid,
    input logic [2:0]        rsp_status,
    input logic [SLOT_W-1:0] rsp_slot,
    input logic              cmd_valid,
    input logic              cmd_clear,
    input logic [SLOT_W-1:0] cmd_slot,
    input logic              lost_valid
);
    // R12: a command issued with a response targets the responded slot.
    p_cmd_slot_match_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && cmd_valid |-> rsp_slot == cmd_slot);

    // R4: a displaced owner is only reported together with a successful install.
    p_lost_with_install_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lost_valid |-> cmd_valid && !cmd_clear && rsp_valid && rsp_status == ST_OK);

    // R3: installs never target slots below the first usable index.
    p_low_slot_unused_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_clear |-> int'(cmd_slot) >= FIRST_SLOT);

    // R5: failed operations emit no command.
    p_fail_no_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_status != ST_OK |-> !cmd_valid);

    // R10: every busy cycle yields a command on the next clock.
    p_restore_stream_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> cmd_valid);

    // R10: the walk advances by one slot per command.
    p_restore_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cmd_valid |=> cmd_slot == SLOT_W'($past(cmd_slot) + 1'b1));

    // R11: operations offered while busy produce no response.
    p_busy_ignores_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rsp_valid);

    // R2: the status code stays inside the defined set.
    p_status_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_status <= 3'd4);
endmodule

bind fence_slot_alloc fence_slot_alloc_chk #(.SLOTS(SLOTS), .FIRST_SLOT(FIRST_SLOT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .rsp_slot   (rsp_slot),
    .cmd_valid  (cmd_valid),
    .cmd_clear  (cmd_clear),
    .cmd_slot   (cmd_slot),
    .lost_valid (lost_valid)
);

// File: tb/fence_slot_alloc_bench.sv
// Self-checking bench: random and directed operations against a timestamp model.
module fence_slot_alloc_bench;
    localparam int N      = 8;
    localparam int FIRST  = 2;
    localparam int ID_W   = 8;
    localparam int PIN_W  = 3;
    localparam int SW     = $clog2(N);
    localparam int PMAX   = (1 << PIN_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic op_valid = 1'b0, op_dirty = 1'b0, retry_hint = 1'b0;
    logic [2:0] op_code = '0;
    logic [ID_W-1:0] op_id = '0;
    logic [SW-1:0] op_slot = '0;
    logic busy, rsp_valid, cmd_valid, cmd_clear, lost_valid;
    logic [2:0] rsp_status;
    logic [SW-1:0] rsp_slot, cmd_slot;
    logic [ID_W-1:0] cmd_id, lost_id;

    int checks = 0, fails = 0;
    bit m_valid [N];
    int m_owner [N];
    int m_pin [N];
    int m_stamp [N];
    int m_clock;

    always #10 clk = ~clk;

    fence_slot_alloc #(.SLOTS(N), .FIRST_SLOT(FIRST), .ID_W(ID_W), .PIN_W(PIN_W)) u_fence_slot_alloc (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_id(op_id),
        .op_slot(op_slot), .op_dirty(op_dirty), .retry_hint(retry_hint), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_slot(rsp_slot),
        .cmd_valid(cmd_valid), .cmd_clear(cmd_clear), .cmd_slot(cmd_slot), .cmd_id(cmd_id),
        .lost_valid(lost_valid), .lost_id(lost_id));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare every output with the expected values one clock after an operation.
    task automatic expect_out(input string req, input bit e_rsp, input int e_st, input int e_slot,
                              input bit e_cmd, input bit e_clr, input int e_cslot, input int e_cid,
                              input bit e_lost, input int e_lid);
        chk(rsp_valid == e_rsp, req, "rsp_valid", rsp_valid, e_rsp);
        if (e_rsp) begin
            chk(rsp_status == 3'(e_st), req, "rsp_status", rsp_status, e_st);
            chk(rsp_slot == SW'(e_slot), req, "rsp_slot", rsp_slot, e_slot);
        end
        chk(cmd_valid == e_cmd, req, "cmd_valid", cmd_valid, e_cmd);
        if (e_cmd) begin
            chk(cmd_clear == e_clr, req, "cmd_clear", cmd_clear, e_clr);
            chk(cmd_slot == SW'(e_cslot), req, "cmd_slot", cmd_slot, e_cslot);
            if (!e_clr) chk(cmd_id == ID_W'(e_cid), req, "cmd_id", cmd_id, e_cid);
        end
        chk(lost_valid == e_lost, req, "lost_valid", lost_valid, e_lost);
        if (e_lost) chk(lost_id == ID_W'(e_lid), req, "lost_id", lost_id, e_lid);
    endtask

    task automatic drive(input int code, input int id, input int slot, input bit dirty, input bit hint);
        op_valid = 1'b1; op_code = 3'(code); op_id = ID_W'(id);
        op_slot = SW'(slot); op_dirty = dirty; retry_hint = hint;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // GET: hit (R2, R6), empty slot (R3), LRU steal (R4), or failure (R5).
    task automatic do_get(input int id, input bit dirty, input bit hint);
        int hit = -1, fr = -1, vic = -1;
        for (int i = 0; i < N; i++) if (m_valid[i] && m_owner[i] == id) hit = i;
        for (int i = N - 1; i >= FIRST; i--) if (!m_valid[i]) fr = i;
        for (int i = FIRST; i < N; i++)
            if (m_valid[i] && m_pin[i] == 0 && (vic < 0 || m_stamp[i] < m_stamp[vic])) vic = i;
        drive(0, id, 0, dirty, hint);
        if (hit >= 0) begin
            expect_out("R2", 1, 0, hit, dirty, 0, hit, id, 0, 0);
            m_stamp[hit] = m_clock++;
        end else if (fr >= 0) begin
            expect_out("R3", 1, 0, fr, 1, 0, fr, id, 0, 0);
            m_valid[fr] = 1; m_owner[fr] = id; m_stamp[fr] = m_clock++;
        end else if (vic >= 0) begin
            expect_out("R4", 1, 0, vic, 1, 0, vic, id, 1, m_owner[vic]);
            m_owner[vic] = id; m_stamp[vic] = m_clock++;
        end else begin
            expect_out("R5", 1, hint ? 1 : 2, 0, 0, 0, 0, 0, 0, 0);
        end
    endtask

    task automatic do_release(input int s);
        drive(1, 0, s, 0, 0);
        if (m_pin[s] != 0) expect_out("R8", 1, 3, s, 0, 0, 0, 0, 0, 0);
        else if (m_valid[s]) begin
            expect_out("R7", 1, 0, s, 1, 1, s, 0, 0, 0);
            m_valid[s] = 0;
        end else expect_out("R7", 1, 0, s, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_pin(input int s, input bit up);
        drive(up ? 2 : 3, 0, s, 0, 0);
        if (up ? (m_pin[s] == PMAX) : (m_pin[s] == 0))
            expect_out("R9", 1, 4, s, 0, 0, 0, 0, 0, 0);
        else begin
            expect_out("R9", 1, 0, s, 0, 0, 0, 0, 0, 0);
            m_pin[s] += up ? 1 : -1;
        end
    endtask

    // RESTORE (R10) with an operation offered during the walk (R11).
    task automatic do_restore();
        drive(4, 0, 0, 0, 0);
        chk(busy == 1'b1, "R10", "busy", busy, 1);
        expect_out("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < N; k++) begin
            if (k == 0) drive(0, 99, 0, 0, 0); else @(negedge clk);
            if (k == 0) chk(rsp_valid == 1'b0, "R11", "rsp while busy", rsp_valid, 0);
            expect_out("R10", 0, 0, 0, 1, !m_valid[k], k, m_owner[k], 0, 0);
            if (k == N - 1) chk(busy == 1'b0, "R10", "busy end", busy, 0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_owner[i] = 0; m_pin[i] = 0; m_stamp[i] = i;
        end
        m_clock = N;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        chk(busy == 1'b0, "R1", "busy", busy, 0);
        expect_out("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // R3: fill eligible slots from FIRST upward; R2: repeat with and without dirty
        for (int id = 10; id < 10 + N - FIRST; id++) do_get(id, 0, 0);
        do_get(10, 0, 0);
        do_get(11, 1, 0);
        // R4: steal skips the refreshed slots; pinned slot never stolen
        do_pin(4, 1);
        do_get(40, 0, 0);
        do_get(41, 0, 0);
        // R8 and R9 corners
        do_release(4);
        do_pin(1, 0);
        for (int k = 0; k <= PMAX; k++) do_pin(5, 1);
        for (int k = 0; k < PMAX; k++) do_pin(5, 0);
        // R5: all eligible slots pinned, both failure codes
        for (int s = FIRST; s < N; s++) if (m_pin[s] == 0) do_pin(s, 1);
        do_get(77, 0, 1);
        do_get(78, 0, 0);
        for (int s = FIRST; s < N; s++) while (m_pin[s] > 0) do_pin(s, 0);
        // R7: release then restore shows a clear for the emptied slot
        do_release(3);
        do_release(3);
        do_restore();
        // R11: undefined opcode ignored; the state it might touch is seen by a later GET
        drive(6, 55, 2, 0, 0);
        expect_out("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        do_get(55, 0, 0);

        // Random mix
        for (int n = 0; n < 1500; n++) begin
            int r = $urandom_range(0, 99);
            int s = $urandom_range(0, N - 1);
            if (r < 50) do_get($urandom_range(0, 13), $urandom_range(0, 1), $urandom_range(0, 1));
            else if (r < 62) do_release(s);
            else if (r < 78) do_pin(s, 1);
            else if (r < 97) do_pin(s, 0);
            else if (r < 98) do_restore();
            else begin
                drive($urandom_range(5, 7), 0, s, 0, 0);
                expect_out("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0);
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule